// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses, at fetch time, whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters and selects one counter by XORing a global outcome history with the word-address bits of the fetch PC. No target cache is kept. When a branch is predicted taken, the fetch side gets its target by adding the sign-extended immediate offset, which the predecoder supplies, to the fetch PC. Otherwise the next fetch address is the sequential one.

The execute stage resolves each branch and sends feedback: the branch PC, its offset, the real outcome, a mispredict flag, and the history snapshot that was current when the branch was fetched. The pipeline carries that snapshot along, and it reads it from `fetch_hist`. Feedback trains the counter that the snapshot indexes and advances the global history. On a mispredict the block raises `flush` and steers the next fetch to the correct path in the same cycle. It also rebuilds the history from the snapshot plus the real outcome. The surrounding pipeline charges one cycle for a correctly predicted not-taken branch, two for a correctly predicted taken branch, and four for a mispredict.

Top module: `gshare_predictor`

## Requirements
- R1: `pred_taken` is high only when `fetch_is_branch` is high and the selected counter is 2 or 3. A counter of 0 or 1, or a fetch that is not a branch, gives `pred_taken` low.
- R2: The fetch-side counter index is the 8-bit value `fetch_pc[9:2] XOR fetch_hist`.
- R3: On a resolution, the counter at index `res_pc[9:2] XOR res_hist` moves up by one for a taken outcome and down by one for a not-taken outcome. It stays at 3 and at 0 instead of wrapping.
- R4: A resolution without mispredict shifts the real outcome into bit 0 of the history, and the older bits move up by one place. With no resolution, the history holds its value.
- R5: A resolution with mispredict sets the history to `{res_hist[6:0], res_taken}`.
- R6: Without flush, `next_pc` is `fetch_pc` plus the sign-extended 16-bit `fetch_offset` when `pred_taken` is high. Otherwise it is `fetch_pc + 4`.
- R7: `flush` equals `res_valid AND res_mispredict`. While `flush` is high, `next_pc` is `res_pc` plus the sign-extended `res_offset` when `res_taken` is high, or `res_pc + 4` when it is low, whatever the fetch inputs are.
- R8: After reset every counter holds 1 (weakly not taken) and the history is 0.
- R9: A counter read and a counter update in the same cycle return the value held before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_pc | input | 32 | Address of the instruction being fetched |
| fetch_is_branch | input | 1 | Predecode marks a conditional branch |
| fetch_offset | input | 16 | Signed byte offset of that branch |
| res_valid | input | 1 | A branch resolution is present |
| res_pc | input | 32 | Address of the resolved branch |
| res_offset | input | 16 | Signed byte offset of the resolved branch |
| res_taken | input | 1 | Real outcome of the resolved branch |
| res_mispredict | input | 1 | The earlier guess for this branch was wrong |
| res_hist | input | 8 | History snapshot taken when the branch was fetched |
| pred_taken | output | 1 | Predicted direction |
| next_pc | output | 32 | Next fetch address |
| flush | output | 1 | Discard younger instructions |
| fetch_hist | output | 8 | Current global history, carried with the branch |

## Verification
A corrupted counter first shows up as a wrong `pred_taken` and `next_pc`, on the next fetch that lands on that index. That fetch can be many cycles later, so the bench ends with a sweep that reads all 256 entries through the fetch port. A bad history update is visible on `fetch_hist` one cycle after the resolution, and it also shifts every later index. A wrong flush or wrong redirect is visible at once, in the resolution cycle itself.

// File: rtl/gshare_pkg.sv
package gshare_pkg;
  localparam int PC_W       = 32;
  localparam int HIST_W     = 8;
  localparam int IDX_W      = HIST_W;
  localparam int ENTRIES    = 1 << IDX_W;
  localparam int CTR_W      = 2;
  localparam int OFF_W      = 16;
  localparam int PC_LSB     = 2;
  localparam int INSN_BYTES = 4;

  typedef logic [PC_W-1:0]   pc_t;
  typedef logic [HIST_W-1:0] hist_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [CTR_W-1:0]  ctr_t;
  typedef logic [OFF_W-1:0]  off_t;

  localparam ctr_t CTR_MAX  = '1;
  localparam ctr_t CTR_MIN  = '0;
  localparam ctr_t CTR_INIT = ctr_t'(1);

  function automatic idx_t table_index(pc_t pc, hist_t h);
    return pc[PC_LSB +: IDX_W] ^ h;
  endfunction

  function automatic ctr_t ctr_next(ctr_t c, logic taken);
    if (taken) return (c == CTR_MAX) ? c : c + ctr_t'(1);
    else       return (c == CTR_MIN) ? c : c - ctr_t'(1);
  endfunction

  function automatic logic ctr_says_taken(ctr_t c);
    return c[CTR_W-1];
  endfunction

  function automatic pc_t seq_pc(pc_t pc);
    return pc + pc_t'(INSN_BYTES);
  endfunction

  function automatic pc_t target_pc(pc_t pc, off_t off);
    return pc + {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
  endfunction

  function automatic hist_t hist_push(hist_t h, logic taken);
    return {h[HIST_W-2:0], taken};
  endfunction
endpackage

// File: rtl/gshare_history.sv
module gshare_history
  import gshare_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  res_valid,
  input  logic  res_mispredict,
  input  logic  res_taken,
  input  hist_t res_hist,
  output hist_t hist_q
);
  hist_t base;
  assign base = res_mispredict ? res_hist : hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hist_q <= '0;
    else if (res_valid) hist_q <= hist_push(base, res_taken);
  end

  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_mispredict) |=>
      (hist_q[0] == $past(res_taken)) &&
      (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(hist_q));

  a_r5_repair: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mispredict) |=>
      (hist_q[0] == $past(res_taken)) &&
      (hist_q[HIST_W-1:1] == $past(res_hist[HIST_W-2:0])));
endmodule

// File: rtl/gshare_table.sv
module gshare_table
  import gshare_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  idx_t rd_idx,
  output ctr_t rd_ctr,
  input  logic wr_en,
  input  idx_t wr_idx,
  input  logic wr_taken
);
  ctr_t ctr_q [ENTRIES];
  ctr_t wr_old;
  ctr_t wr_new;

  assign wr_old = ctr_q[wr_idx];
  assign wr_new = ctr_next(wr_old, wr_taken);
  assign rd_ctr = ctr_q[rd_idx];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ctr_q[e] <= CTR_INIT;
      else if (wr_en && (wr_idx == idx_t'(e))) ctr_q[e] <= wr_new;
    end
  end

  // Observation path for the assertions: value now held at last cycle's write index.
  idx_t wr_idx_q;
  ctr_t post_val;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_idx_q <= '0;
    else        wr_idx_q <= wr_idx;
  end
  assign post_val = ctr_q[wr_idx_q];

  a_r3_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_old == CTR_MAX) |=> post_val == CTR_MAX);

  a_r3_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_old == CTR_MIN) |=> post_val == CTR_MIN);

  a_r3_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_old != CTR_MIN && wr_old != CTR_MAX) |=> post_val != $past(wr_old));
endmodule

// File: rtl/gshare_redirect.sv
module gshare_redirect
  import gshare_pkg::*;
(
  input  pc_t  fetch_pc,
  input  off_t fetch_offset,
  input  logic pred_taken,
  input  logic flush,
  input  pc_t  res_pc,
  input  off_t res_offset,
  input  logic res_taken,
  output pc_t  next_pc
);
  pc_t fetch_next;
  pc_t fix_next;

  assign fetch_next = pred_taken ? target_pc(fetch_pc, fetch_offset) : seq_pc(fetch_pc);
  assign fix_next   = res_taken  ? target_pc(res_pc, res_offset)     : seq_pc(res_pc);
  assign next_pc    = flush ? fix_next : fetch_next;
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] fetch_pc,
  input  logic        fetch_is_branch,
  input  logic [15:0] fetch_offset,
  input  logic        res_valid,
  input  logic [31:0] res_pc,
  input  logic [15:0] res_offset,
  input  logic        res_taken,
  input  logic        res_mispredict,
  input  logic [7:0]  res_hist,
  output logic        pred_taken,
  output logic [31:0] next_pc,
  output logic        flush,
  output logic [7:0]  fetch_hist
);
  hist_t ghr;
  idx_t  fetch_idx;
  idx_t  upd_idx;
  ctr_t  fetch_ctr;

  gshare_history u_hist (
    .clk(clk), .rst_n(rst_n),
    .res_valid(res_valid), .res_mispredict(res_mispredict),
    .res_taken(res_taken), .res_hist(res_hist),
    .hist_q(ghr)
  );

  assign fetch_idx = table_index(fetch_pc, ghr);
  assign upd_idx   = table_index(res_pc, res_hist);

  gshare_table u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(fetch_idx), .rd_ctr(fetch_ctr),
    .wr_en(res_valid), .wr_idx(upd_idx), .wr_taken(res_taken)
  );

  assign pred_taken = fetch_is_branch & ctr_says_taken(fetch_ctr);
  assign flush      = res_valid & res_mispredict;
  assign fetch_hist = ghr;

  gshare_redirect u_redir (
    .fetch_pc(fetch_pc), .fetch_offset(fetch_offset),
    .pred_taken(pred_taken), .flush(flush),
    .res_pc(res_pc), .res_offset(res_offset), .res_taken(res_taken),
    .next_pc(next_pc)
  );

  a_r1_needs_branch: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_is_branch |-> !pred_taken);

  a_r7_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (res_valid && res_mispredict));
endmodule

// File: tb/gshare_predictor_test.sv
module gshare_predictor_test;
  localparam time PERIOD = 20ns;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] fetch_pc = 0;
  logic        fetch_is_branch = 0;
  logic [15:0] fetch_offset = 0;
  logic        res_valid = 0;
  logic [31:0] res_pc = 0;
  logic [15:0] res_offset = 0;
  logic        res_taken = 0;
  logic        res_mispredict = 0;
  logic [7:0]  res_hist = 0;
  logic        pred_taken;
  logic [31:0] next_pc;
  logic        flush;
  logic [7:0]  fetch_hist;

  gshare_predictor uut (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int m_ctr [256];
  logic [7:0] m_ghr;
  logic [31:0] rng = 32'h1ACE_B00C;
  bit done = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(logic [15:0] o);
    return {{16{o[15]}}, o};
  endfunction

  function automatic logic [31:0] rnd();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  // Called at a negedge: drive, check combinational results, step a clock, update the model.
  task automatic step(logic [31:0] fpc, logic fbr, logic [15:0] foff,
                      logic rv, logic [31:0] rpc, logic [15:0] roff,
                      logic rt, logic rm, logic [7:0] rh);
    logic [7:0] fi, ui;
    logic ep, ef;
    logic [31:0] en;
    fetch_pc = fpc; fetch_is_branch = fbr; fetch_offset = foff;
    res_valid = rv; res_pc = rpc; res_offset = roff;
    res_taken = rt; res_mispredict = rm; res_hist = rh;
    #1;
    fi = fpc[9:2] ^ m_ghr;                                   // R2
    ep = fbr && (m_ctr[fi] >= 2);                            // R1, R9
    ef = rv && rm;                                           // R7
    if (ef)      en = rt ? rpc + sx(roff) : rpc + 4;         // R7
    else if (ep) en = fpc + sx(foff);                        // R6
    else         en = fpc + 4;
    chk(pred_taken == ep, "R1/R2 pred_taken", 32'(pred_taken), 32'(ep));
    chk(flush == ef, "R7 flush", 32'(flush), 32'(ef));
    chk(next_pc == en, "R6/R7 next_pc", next_pc, en);
    chk(fetch_hist == m_ghr, "R4/R5 history", 32'(fetch_hist), 32'(m_ghr));
    @(posedge clk);
    if (rv) begin
      ui = rpc[9:2] ^ rh;                                    // R3
      if (rt) m_ctr[ui] = (m_ctr[ui] == 3) ? 3 : m_ctr[ui] + 1;
      else    m_ctr[ui] = (m_ctr[ui] == 0) ? 0 : m_ctr[ui] - 1;
      m_ghr = rm ? {rh[6:0], rt} : {m_ghr[6:0], rt};         // R4, R5
    end
    @(negedge clk);
  endtask

  // R8/R1: read every entry through the fetch port, no resolution.
  task automatic sweep_all(logic br);
    for (int i = 0; i < 256; i++) begin
      logic [31:0] pc;
      pc = 32'h4000_0000 | {22'd0, (8'(i) ^ m_ghr), 2'b00};
      step(pc, br, 16'hFFF0, 0, 0, 0, 0, 0, 0);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m_ctr[i] = 1;
    m_ghr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fetch_hist == 0, "R8 reset history", 32'(fetch_hist), 0);
    rst_n = 1;
    @(negedge clk);

    // R8: all counters weakly not-taken after reset; R1 with non-branch.
    sweep_all(1);
    sweep_all(0);

    // R3: drive one index to saturation high and low; R9 same-cycle read/write.
    for (int k = 0; k < 6; k++)
      step(32'h0000_0040, 1, 16'h0100, 1, 32'h0000_0040, 16'h0100, 1, 0, 8'h00);
    for (int k = 0; k < 6; k++)
      step(32'h0000_0044, 1, 16'h0010, 1, 32'h0000_0040, 16'h0080, 0, 0, 8'h00);

    // R5: repair from a snapshot different from the live history.
    step(32'h0000_1000, 1, 16'h0008, 1, 32'h0000_2000, 16'h8000, 1, 1, 8'hA5);
    chk(fetch_hist == 8'h4B, "R5 repaired history", 32'(fetch_hist), 32'h4B);
    step(32'h0000_1000, 1, 16'h0008, 1, 32'h0000_2000, 16'h7FFC, 0, 1, 8'h5A);
    chk(fetch_hist == 8'hB4, "R5 repaired history", 32'(fetch_hist), 32'hB4);

    // R4, R6, R7: mixed random traffic.
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b, c;
      a = rnd(); b = rnd(); c = rnd();
      step({a[31:2], 2'b00}, c[0], a[15:0] & 16'hFFFC,
           c[1] | c[2], {b[31:2], 2'b00}, b[15:0] & 16'hFFFC,
           c[3], c[4] & c[5], c[6] ? m_ghr : c[15:8]);
    end

    // Final readout of the whole table.
    sweep_all(1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule